// File: doc/BRIEF.md
# Interrupt Controller Command and Configuration Port

This block is the byte-wide register front end of an eight-line programmable interrupt controller. Software reaches it through two addresses. Address 0 takes the start of an initialization sequence and the run-time command bytes. Address 1 takes the configuration words of that sequence and, in normal operation, the line mask. The block holds the line mask, the vector base, the in-service register, the rotating priority offset and the mode flags. It turns each command byte into end-of-interrupt, rotation, poll and read-select actions.

The pending-request latch and the priority resolver sit outside the block. The resolver reports the winning pending line and the highest-priority in-service line, and the block acts on those reports. When an in-service bit is cleared, the block raises a one-cycle pulse that carries the line number. A poll read also raises a one-cycle pulse that tells the request latch which pending bit to drop.

The initialization sequencer is a four-state machine:
- `ST_NORMAL`: the idle state. Address-1 writes load the mask.
- `ST_GET_BASE`: waits for the vector-base word.
- `ST_GET_W3`: waits for the third word, whose content is discarded.
- `ST_GET_W4`: waits for the optional mode word.

Its transitions are as follows:
- An init write moves from any state to `ST_GET_BASE`.
- `ST_GET_BASE` moves to `ST_GET_W3` on a data write.
- `ST_GET_W3` moves to `ST_GET_W4` on a data write if the mode word was requested. Otherwise it moves to `ST_NORMAL`.
- `ST_GET_W4` moves to `ST_NORMAL` on a data write.

Top module: `pic_prog_if`

## Requirements
- R1: After reset, the mask, vector base, in-service register, priority offset and all mode flags are zero, the sequencer is in `ST_NORMAL`, and a read at address 0 returns the pending vector `irr_in`.
- R2: An address-0 write with data bit 4 set starts initialization. It clears the mask, vector base, in-service register, offset, poll, read-select, special mask, rotate-on-auto-EOI, auto-EOI and special nesting. Data bit 0 records whether a mode word will follow.
- R3: The first address-1 write after an init write sets the vector base to the data with its low three bits forced to zero.
- R4: The next address-1 write is accepted and its content is discarded, so the mask is unchanged. If no mode word was requested, the following address-1 write loads the mask.
- R5: When the mode word was requested, the fourth word sets special nesting from data bit 4 and auto-EOI from data bit 1, and the sequencer returns to `ST_NORMAL`.
- R6: In `ST_NORMAL`, an address-1 write loads the mask on that clock edge. A non-poll read at address 1 returns the mask.
- R7: An address-0 write with bit 4 clear and bit 3 set works as follows. Bit 2 sets poll. Bit 1 enables an update of read-select from bit 0, where 1 means in-service and 0 means pending. Bit 6 enables an update of special mask from bit 5. A non-poll read at address 0 returns the in-service register when read-select is 1.
- R8: An address-0 write with bits 4 and 3 clear carries a command code in bits 7:5. Code 0 clears rotate-on-auto-EOI and code 4 sets it.
- R9: Code 1 clears the in-service bit that the resolver reports as highest priority. Code 5 does the same and also sets the offset to that line plus 1, modulo 8. Each clear gives a one-cycle pulse on `clr_valid`, with the line on `clr_line`.
- R10: Code 3 clears the in-service bit named by data bits 2:0. Code 7 does the same and also sets the offset to that line plus 1. Code 6 only sets the offset to data bits 2:0 plus 1. All offset arithmetic is modulo 8.
- R11: Code 2 changes no state and raises no pulse.
- R12: An acknowledge sets the in-service bit of the winning line. With auto-EOI on, the bit is cleared again at once and a clear pulse is raised. If rotate-on-auto-EOI is also set, the offset becomes that line plus 1.
- R13: A read while poll is set, at either address, returns the winning line number. It clears that line's in-service bit, pulses `pend_clr_valid` with the line, and clears poll. With no winner the read returns 7 and clears poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| irr_in | input | 8 | Pending vector from the request latch |
| ack_en | input | 1 | Interrupt acknowledge strobe |
| win_valid | input | 1 | Resolver has a winning pending line |
| win_line | input | 3 | Winning pending line |
| isr_hi_valid | input | 1 | At least one in-service bit is set |
| isr_hi_line | input | 3 | Highest-priority in-service line |
| rdata | output | 8 | Read data |
| imr | output | 8 | Line mask |
| vec_base | output | 8 | Vector base |
| isr | output | 8 | In-service register |
| prio_offset | output | 3 | Rotating priority offset |
| auto_eoi | output | 1 | Auto-EOI mode |
| rot_on_aeoi | output | 1 | Rotate on auto-EOI |
| spec_nest | output | 1 | Special nesting mode |
| spec_mask | output | 1 | Special mask mode |
| poll_mode | output | 1 | Poll armed |
| read_isr | output | 1 | Read-select: 1 means in-service |
| clr_valid | output | 1 | In-service clear pulse |
| clr_line | output | 3 | Line of the in-service clear |
| pend_clr_valid | output | 1 | Pending clear pulse from a poll read |
| pend_clr_line | output | 3 | Line of the pending clear |

## Verification
Every write, acknowledge and poll read updates state on the clock edge where its strobe is high. The clear pulses appear in the cycle after that edge and last exactly one cycle. The read data is combinational, so it is valid in the same cycle as the read strobe. The bench drives strobes at falling edges and samples `rdata` shortly after raising `rd_en`. It samples state and pulses at the next falling edge, one edge after the strobe. One idle cycle later it confirms that the pulse has dropped.

// File: rtl/pic_prog_pkg.sv
package pic_prog_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL   = 2'd0,
        ST_GET_BASE = 2'd1,
        ST_GET_W3   = 2'd2,
        ST_GET_W4   = 2'd3
    } init_st_t;

    typedef enum logic [2:0] {
        OP_ROT_AEOI_OFF = 3'd0,
        OP_EOI_NS       = 3'd1,
        OP_NOP          = 3'd2,
        OP_EOI_SP       = 3'd3,
        OP_ROT_AEOI_ON  = 3'd4,
        OP_EOI_NS_ROT   = 3'd5,
        OP_SET_PRIO     = 3'd6,
        OP_EOI_SP_ROT   = 3'd7
    } op_code_t;

    // Command-byte bit positions that the decoders rely on.
    localparam int B_INIT      = 4;
    localparam int B_CMD3      = 3;
    localparam int B_POLL      = 2;
    localparam int B_RSEL_EN   = 1;
    localparam int B_RSEL      = 0;
    localparam int B_SMASK_EN  = 6;
    localparam int B_SMASK     = 5;
    localparam int B_NEED_W4   = 0;
    localparam int B_W4_NEST   = 4;
    localparam int B_W4_AEOI   = 1;

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_prog_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [LINES-1:0] wdata,
    output logic             init_hit,
    output logic [LINES-1:0] imr,
    output logic [LINES-1:0] vec_base,
    output logic             spec_nest,
    output logic             auto_eoi
);

    init_st_t state, state_nxt;
    logic     need_w4;
    logic     data_wr;

    assign init_hit = wr_en && !addr && wdata[B_INIT];
    assign data_wr  = wr_en && addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_NORMAL;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (init_hit) begin
            state_nxt = ST_GET_BASE;
        end else if (data_wr) begin
            unique case (state)
                ST_NORMAL:   state_nxt = ST_NORMAL;
                ST_GET_BASE: state_nxt = ST_GET_W3;
                ST_GET_W3:   state_nxt = need_w4 ? ST_GET_W4 : ST_NORMAL;
                ST_GET_W4:   state_nxt = ST_NORMAL;
                default:     state_nxt = ST_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            need_w4   <= 1'b0;
            imr       <= '0;
            vec_base  <= '0;
            spec_nest <= 1'b0;
            auto_eoi  <= 1'b0;
        end else if (init_hit) begin
            need_w4   <= wdata[B_NEED_W4];
            imr       <= '0;
            vec_base  <= '0;
            spec_nest <= 1'b0;
            auto_eoi  <= 1'b0;
        end else if (data_wr) begin
            unique case (state)
                ST_NORMAL:   imr <= wdata;
                ST_GET_BASE: vec_base <= {wdata[LINES-1:LW], {LW{1'b0}}};
                ST_GET_W3:   ;
                ST_GET_W4: begin
                    spec_nest <= wdata[B_W4_NEST];
                    auto_eoi  <= wdata[B_W4_AEOI];
                end
                default: ;
            endcase
        end
    end

    assert_init_enters_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_hit |=> (state == ST_GET_BASE));

    assert_base_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state == ST_GET_BASE) |=> (vec_base[LW-1:0] == '0));

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state == ST_NORMAL) |=> (imr == $past(wdata)));

    assert_w3_keeps_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state == ST_GET_W3) |=> $stable(imr));

endmodule

// File: rtl/pic_cmd_unit.sv
module pic_cmd_unit
    import pic_prog_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [LINES-1:0] wdata,
    input  logic             init_hit,
    input  logic             auto_eoi,
    input  logic             ack_en,
    input  logic             win_valid,
    input  logic [LW-1:0]    win_line,
    input  logic             isr_hi_valid,
    input  logic [LW-1:0]    isr_hi_line,
    output logic [LINES-1:0] isr,
    output logic [LW-1:0]    prio_offset,
    output logic             rot_on_aeoi,
    output logic             poll_mode,
    output logic             read_isr,
    output logic             spec_mask,
    output logic             clr_valid,
    output logic [LW-1:0]    clr_line,
    output logic             pend_clr_valid,
    output logic [LW-1:0]    pend_clr_line
);

    logic             cmd2_hit, cmd3_hit, poll_rd, ack_hit;
    op_code_t         op;
    logic [LW-1:0]    sel_line;
    logic [LINES-1:0] set_vec, clr_vec;
    logic             off_we, rot_we, rot_val;
    logic [LW-1:0]    off_nxt;
    logic             pulse_v;
    logic [LW-1:0]    pulse_l;

    assign cmd3_hit = wr_en && !addr && !wdata[B_INIT] &&  wdata[B_CMD3];
    assign cmd2_hit = wr_en && !addr && !wdata[B_INIT] && !wdata[B_CMD3];
    assign op       = op_code_t'(wdata[LINES-1:LINES-3]);
    assign sel_line = wdata[LW-1:0];
    assign poll_rd  = rd_en && poll_mode;
    assign ack_hit  = ack_en && win_valid;

    // Same-edge precedence: acknowledge, then poll read, then command.
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        off_we  = 1'b0;
        off_nxt = prio_offset;
        rot_we  = 1'b0;
        rot_val = rot_on_aeoi;
        pulse_v = 1'b0;
        pulse_l = '0;

        if (ack_hit) begin
            set_vec[win_line] = 1'b1;
            if (auto_eoi) begin
                clr_vec[win_line] = 1'b1;
                pulse_v = 1'b1;
                pulse_l = win_line;
                if (rot_on_aeoi) begin
                    off_we  = 1'b1;
                    off_nxt = win_line + 1'b1;
                end
            end
        end

        if (poll_rd && win_valid) begin
            clr_vec[win_line] = 1'b1;
            pulse_v = 1'b1;
            pulse_l = win_line;
        end

        if (cmd2_hit) begin
            unique case (op)
                OP_ROT_AEOI_OFF: begin rot_we = 1'b1; rot_val = 1'b0; end
                OP_ROT_AEOI_ON:  begin rot_we = 1'b1; rot_val = 1'b1; end
                OP_EOI_NS, OP_EOI_NS_ROT: begin
                    if (isr_hi_valid) begin
                        clr_vec[isr_hi_line] = 1'b1;
                        pulse_v = 1'b1;
                        pulse_l = isr_hi_line;
                        if (op == OP_EOI_NS_ROT) begin
                            off_we  = 1'b1;
                            off_nxt = isr_hi_line + 1'b1;
                        end
                    end
                end
                OP_EOI_SP, OP_EOI_SP_ROT: begin
                    clr_vec[sel_line] = 1'b1;
                    pulse_v = 1'b1;
                    pulse_l = sel_line;
                    if (op == OP_EOI_SP_ROT) begin
                        off_we  = 1'b1;
                        off_nxt = sel_line + 1'b1;
                    end
                end
                OP_SET_PRIO: begin
                    off_we  = 1'b1;
                    off_nxt = sel_line + 1'b1;
                end
                OP_NOP: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr            <= '0;
            prio_offset    <= '0;
            rot_on_aeoi    <= 1'b0;
            poll_mode      <= 1'b0;
            read_isr       <= 1'b0;
            spec_mask      <= 1'b0;
            clr_valid      <= 1'b0;
            clr_line       <= '0;
            pend_clr_valid <= 1'b0;
            pend_clr_line  <= '0;
        end else if (init_hit) begin
            isr            <= '0;
            prio_offset    <= '0;
            rot_on_aeoi    <= 1'b0;
            poll_mode      <= 1'b0;
            read_isr       <= 1'b0;
            spec_mask      <= 1'b0;
            clr_valid      <= 1'b0;
            pend_clr_valid <= 1'b0;
        end else begin
            isr       <= (isr | set_vec) & ~clr_vec;
            clr_valid <= pulse_v;
            clr_line  <= pulse_l;
            pend_clr_valid <= poll_rd && win_valid;
            pend_clr_line  <= win_line;
            if (off_we) prio_offset <= off_nxt;
            if (rot_we) rot_on_aeoi <= rot_val;
            if (poll_rd) poll_mode <= 1'b0;
            if (cmd3_hit) begin
                if (wdata[B_POLL])     poll_mode <= 1'b1;
                if (wdata[B_RSEL_EN])  read_isr  <= wdata[B_RSEL];
                if (wdata[B_SMASK_EN]) spec_mask <= wdata[B_SMASK];
            end
        end
    end

    assert_clr_pulse_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> !isr[clr_line]);

    assert_poll_oneshot_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_mode && !wr_en) |=> !poll_mode);

    assert_offset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ack_en) |=> $stable(prio_offset));

    assert_ack_sets_isr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && win_valid && !auto_eoi && !wr_en && !rd_en) |=> isr[$past(win_line)]);

endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic             addr,
    input  logic             poll_mode,
    input  logic             read_isr,
    input  logic             win_valid,
    input  logic [LW-1:0]    win_line,
    input  logic [LINES-1:0] imr,
    input  logic [LINES-1:0] isr,
    input  logic [LINES-1:0] irr_in,
    output logic [LINES-1:0] rdata
);

    localparam logic [LW-1:0] NO_WIN = LW'(LINES - 1);

    always_comb begin
        if (poll_mode)
            rdata = {{(LINES-LW){1'b0}}, (win_valid ? win_line : NO_WIN)};
        else if (addr)
            rdata = imr;
        else if (read_isr)
            rdata = isr;
        else
            rdata = irr_in;
    end

endmodule

// File: rtl/pic_prog_if.sv
module pic_prog_if #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [LINES-1:0] wdata,
    input  logic [LINES-1:0] irr_in,
    input  logic             ack_en,
    input  logic             win_valid,
    input  logic [LW-1:0]    win_line,
    input  logic             isr_hi_valid,
    input  logic [LW-1:0]    isr_hi_line,
    output logic [LINES-1:0] rdata,
    output logic [LINES-1:0] imr,
    output logic [LINES-1:0] vec_base,
    output logic [LINES-1:0] isr,
    output logic [LW-1:0]    prio_offset,
    output logic             auto_eoi,
    output logic             rot_on_aeoi,
    output logic             spec_nest,
    output logic             spec_mask,
    output logic             poll_mode,
    output logic             read_isr,
    output logic             clr_valid,
    output logic [LW-1:0]    clr_line,
    output logic             pend_clr_valid,
    output logic [LW-1:0]    pend_clr_line
);

    logic init_hit;

    pic_init_seq #(.LINES(LINES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .init_hit  (init_hit),
        .imr       (imr),
        .vec_base  (vec_base),
        .spec_nest (spec_nest),
        .auto_eoi  (auto_eoi)
    );

    pic_cmd_unit #(.LINES(LINES)) u_cmd (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .rd_en          (rd_en),
        .addr           (addr),
        .wdata          (wdata),
        .init_hit       (init_hit),
        .auto_eoi       (auto_eoi),
        .ack_en         (ack_en),
        .win_valid      (win_valid),
        .win_line       (win_line),
        .isr_hi_valid   (isr_hi_valid),
        .isr_hi_line    (isr_hi_line),
        .isr            (isr),
        .prio_offset    (prio_offset),
        .rot_on_aeoi    (rot_on_aeoi),
        .poll_mode      (poll_mode),
        .read_isr       (read_isr),
        .spec_mask      (spec_mask),
        .clr_valid      (clr_valid),
        .clr_line       (clr_line),
        .pend_clr_valid (pend_clr_valid),
        .pend_clr_line  (pend_clr_line)
    );

    pic_read_mux #(.LINES(LINES)) u_rd (
        .addr      (addr),
        .poll_mode (poll_mode),
        .read_isr  (read_isr),
        .win_valid (win_valid),
        .win_line  (win_line),
        .imr       (imr),
        .isr       (isr),
        .irr_in    (irr_in),
        .rdata     (rdata)
    );

    assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_hit |=> (isr == '0 && imr == '0 && prio_offset == '0 && !poll_mode));

endmodule

// File: tb/tb_pic_prog_if.sv
module tb_pic_prog_if;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack_en = 1'b0;
    logic [7:0] wdata = '0, irr_in = '0;
    logic       win_valid, isr_hi_valid;
    logic [2:0] win_line, isr_hi_line;
    logic [7:0] rdata, imr, vec_base, isr;
    logic [2:0] prio_offset, clr_line, pend_clr_line;
    logic       auto_eoi, rot_on_aeoi, spec_nest, spec_mask, poll_mode, read_isr;
    logic       clr_valid, pend_clr_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pic_prog_if dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .irr_in(irr_in), .ack_en(ack_en), .win_valid(win_valid),
        .win_line(win_line), .isr_hi_valid(isr_hi_valid), .isr_hi_line(isr_hi_line),
        .rdata(rdata), .imr(imr), .vec_base(vec_base), .isr(isr),
        .prio_offset(prio_offset), .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi),
        .spec_nest(spec_nest), .spec_mask(spec_mask), .poll_mode(poll_mode),
        .read_isr(read_isr), .clr_valid(clr_valid), .clr_line(clr_line),
        .pend_clr_valid(pend_clr_valid), .pend_clr_line(pend_clr_line)
    );

    // Bench model of the external resolver: rotating priority from prio_offset.
    function automatic logic [3:0] pick(input logic [7:0] m, input logic [2:0] off);
        for (int i = 0; i < 8; i++) begin
            logic [2:0] l;
            l = off + 3'(i);
            if (m[l]) return {1'b1, l};
        end
        return 4'd0;
    endfunction

    always_comb begin
        logic [3:0] p, q;
        logic [2:0] rp, rq;
        p  = pick(irr_in & ~imr, prio_offset);
        q  = pick(isr, prio_offset);
        rp = p[2:0] - prio_offset;
        rq = q[2:0] - prio_offset;
        win_valid    = p[3] && (!q[3] || rp < rq);
        win_line     = p[2:0];
        isr_hi_valid = q[3];
        isr_hi_line  = q[2:0];
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_ack(input int l);
        @(negedge clk);
        irr_in = 8'(1 << l);
        #1 chk("R12 winner ready", {31'd0, win_valid}, 1);
        ack_en = 1'b1;
        @(negedge clk);
        ack_en = 1'b0;
        irr_in = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        irr_in = 8'h5A;
        chk("R1 imr", imr, 0);
        chk("R1 isr", isr, 0);
        chk("R1 offset", prio_offset, 0);
        chk("R1 base", vec_base, 0);
        chk("R1 modes", {auto_eoi, rot_on_aeoi, spec_nest, spec_mask, poll_mode, read_isr}, 0);
        rd(1'b0, v);
        chk("R1 read pending", v, 8'h5A);
        irr_in = '0;
    endtask

    task automatic t_init();
        logic [7:0] v;
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h47);
        chk("R3 base", vec_base, 8'h40);
        wr(1'b1, 8'hFF);
        chk("R4 third word ignored", imr, 0);
        wr(1'b1, 8'h12);
        chk("R5 nest", spec_nest, 1);
        chk("R5 aeoi", auto_eoi, 1);
        wr(1'b1, 8'h3C);
        chk("R6 mask", imr, 8'h3C);
        rd(1'b1, v);
        chk("R6 read mask", v, 8'h3C);
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'hC4);
        wr(1'b0, 8'h10);
        chk("R2 mask cleared", imr, 0);
        chk("R2 modes cleared", {auto_eoi, spec_nest, read_isr}, 0);
        chk("R2 offset cleared", prio_offset, 0);
        chk("R2 base cleared", vec_base, 0);
        wr(1'b1, 8'h08);
        chk("R3 base 2", vec_base, 8'h08);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h81);
        chk("R4 no fourth word, mask loads", imr, 8'h81);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_ocw3();
        logic [7:0] v;
        do_ack(2);
        chk("R12 ack sets isr", isr, 8'h04);
        irr_in = 8'h80;
        wr(1'b0, 8'h0B);
        chk("R7 read_isr set", read_isr, 1);
        rd(1'b0, v);
        chk("R7 read isr", v, 8'h04);
        wr(1'b0, 8'h08);
        chk("R7 rsel held without bit1", read_isr, 1);
        wr(1'b0, 8'h0A);
        rd(1'b0, v);
        chk("R7 read pending", v, 8'h80);
        wr(1'b0, 8'h68);
        chk("R7 smask on", spec_mask, 1);
        wr(1'b0, 8'h28);
        chk("R7 smask held without bit6", spec_mask, 1);
        wr(1'b0, 8'h48);
        chk("R7 smask off", spec_mask, 0);
        irr_in = '0;
    endtask

    task automatic t_eoi();
        do_ack(0);
        chk("R12 isr two bits", isr, 8'h05);
        wr(1'b0, 8'h20);
        chk("R9 ns eoi isr", isr, 8'h04);
        chk("R9 pulse", {clr_valid, clr_line}, {1'b1, 3'd0});
        @(negedge clk);
        chk("R9 pulse one cycle", clr_valid, 0);
        wr(1'b0, 8'hA0);
        chk("R9 rot eoi isr", isr, 0);
        chk("R9 rot offset", prio_offset, 3);
        chk("R9 rot pulse", {clr_valid, clr_line}, {1'b1, 3'd2});
        do_ack(6);
        do_ack(4);
        chk("R12 rotated acks", isr, 8'h50);
        wr(1'b0, 8'h66);
        chk("R10 specific clear", isr, 8'h10);
        chk("R10 specific pulse", {clr_valid, clr_line}, {1'b1, 3'd6});
        chk("R10 specific keeps offset", prio_offset, 3);
        wr(1'b0, 8'h40);
        chk("R11 nop isr", isr, 8'h10);
        chk("R11 nop offset", prio_offset, 3);
        chk("R11 nop no pulse", clr_valid, 0);
        wr(1'b0, 8'hE4);
        chk("R10 code7 isr", isr, 0);
        chk("R10 code7 offset", prio_offset, 5);
        chk("R10 code7 pulse", {clr_valid, clr_line}, {1'b1, 3'd4});
        wr(1'b0, 8'hC7);
        chk("R10 code6 wrap", prio_offset, 0);
    endtask

    task automatic t_rot_flag();
        wr(1'b0, 8'h80);
        chk("R8 rotate on", rot_on_aeoi, 1);
        wr(1'b0, 8'h00);
        chk("R8 rotate off", rot_on_aeoi, 0);
    endtask

    task automatic t_aeoi();
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h02);
        chk("R5 aeoi only", {spec_nest, auto_eoi}, 2'b01);
        wr(1'b0, 8'h80);
        do_ack(3);
        chk("R12 aeoi isr stays clear", isr, 0);
        chk("R12 aeoi pulse", {clr_valid, clr_line}, {1'b1, 3'd3});
        chk("R12 aeoi rotate", prio_offset, 4);
    endtask

    task automatic t_poll();
        logic [7:0] v;
        irr_in = 8'h02;
        wr(1'b0, 8'h0C);
        chk("R13 poll armed", poll_mode, 1);
        rd(1'b1, v);
        chk("R13 poll winner", v, 1);
        chk("R13 poll cleared", poll_mode, 0);
        chk("R13 pend pulse", {pend_clr_valid, pend_clr_line}, {1'b1, 3'd1});
        irr_in = '0;
        wr(1'b0, 8'h0C);
        rd(1'b0, v);
        chk("R13 poll no winner", v, 7);
        chk("R13 poll cleared 2", poll_mode, 0);
        chk("R13 no pend pulse", pend_clr_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_ocw3();
        t_eoi();
        t_rot_flag();
        t_aeoi();
        t_poll();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule